// File: doc/BRIEF.md
# SPI Master with Routed Peripheral Interrupt

This block is a single-slave SPI master driven by a host through two write strobes and two read ports. An 8-bit control/status byte selects the serial clock rate, the bit order, whether the peripheral's interrupt is forwarded, and which of four interrupt lines carries it. Writing a byte to the data port while the engine is idle starts an 8-bit SPI mode 0 exchange. The byte goes out on `mosi` while the reply is collected from `miso`.

The serial clock comes from a counter that toggles `sclk` every `h` system cycles. `h = HALF_MAX >> rate`, so each step of the 2-bit rate code doubles the SCLK frequency. With the default `HALF_MAX = 16` and a 33 MHz reference, this gives division by 32, 16, 8 and 4. Rate and bit order are captured when a transfer starts. A control write during a transfer therefore only affects the next one.

The peripheral's active-low interrupt input passes through two flops. The synchronized level appears in a read-only status bit. When forwarding is enabled, it also drives exactly one of the four interrupt outputs.

Top module: `spi_irq_master`

## Requirements
- R1: The control byte holds irqSel in bits 7:6, rate in bits 5:4, irqEnable in bit 3 and lsbFirst in bit 2. All of these are writable and reset to 0. Bit 1 reads the device-interrupt status and bit 0 reads busy, and writes to bits 1:0 have no effect.
- R2: When irqEnable is 1 and the synchronized device interrupt is active, `irqLine[irqSel]` is 1 and every other line is 0.
- R3: When irqEnable is 0, all of `irqLine` stays 0 regardless of `devIntN`.
- R4: Status bit 1 equals the inverse of `devIntN` as sampled two clock edges earlier. It is set while the input is low and clears only once the input returns high.
- R5: A data write while idle starts a transfer: `csN` is 0 from the next cycle. In mode 0, `sclk` is 0 whenever `csN` is 1, `mosi` changes only after falling `sclk` edges, and `miso` is sampled at rising edges.
- R6: With `h = HALF_MAX >> rate`, `sclk` toggles at h, 2h, … 16h cycles after the write edge. `csN` returns to 1 at 17h cycles.
- R7: With lsbFirst = 0, transmit bit 7 goes out first and received bits enter at bit 0, shifting left. With lsbFirst = 1, bit 0 goes out first and received bits enter at bit 7, shifting right. Rate and order are captured at transfer start.
- R8: Status bit 0 reads 1 from the cycle after the starting write until the cycle `csN` returns high.
- R9: A data write while busy is ignored: it neither restarts nor alters the transfer in progress.
- R10: After busy falls, the data read port holds the 8 received bits, arranged so the slave's byte reads back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| csrWr | input | 1 | Write strobe for the control byte |
| dataWr | input | 1 | Write strobe for the transmit byte (starts a transfer) |
| wrData | input | 8 | Write data shared by both strobes |
| csrRd | output | 8 | Control/status byte read value |
| dataRd | output | 8 | Received byte |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data to slave |
| miso | input | 1 | Serial data from slave |
| csN | output | 1 | Active-low slave select |
| devIntN | input | 1 | Active-low peripheral interrupt |
| irqLine | output | 4 | Routed interrupt outputs, index = irqSel |

## Verification
The bench builds the block with `HALF_MAX = 8`, so the four rate codes give half periods of 8, 4, 2 and 1 cycles. The slowest transfer then finishes in 136 cycles, which leaves room to sweep every rate with both bit orders. The one-cycle half period is included, where the counter compare wraps on every cycle and rise and fall strobes come back to back. A closed-form timing model predicts `sclk`, `csN`, `mosi` and status from the cycle count since the start write. A slave model returns a known byte, so the bit ordering of the receive path is checked end to end.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_TAIL = 2'd2
  } spiState_t;

  // strobes from control to datapath, one cycle wide
  typedef struct packed {
    logic load;     // latch tx byte and bit order
    logic capture;  // rising sclk: sample miso
    logic shift;    // falling sclk: advance tx
  } spiStrobe_t;

endpackage

// File: rtl/spi_irq_ctrl.sv
module spi_irq_ctrl
  import spi_irq_pkg::*;
#(
  parameter int HALF_MAX = 16,
  parameter int DATA_W   = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       dataWr,
  input  logic [1:0] rateSel,
  output spiStrobe_t stb,
  output logic       sclk,
  output logic       csN,
  output logic       busy
);

  localparam int CNT_W  = $clog2(HALF_MAX + 1);
  localparam int EDGES  = 2 * DATA_W;
  localparam int EDGE_W = $clog2(EDGES);
  localparam logic [EDGE_W-1:0] LAST_EDGE = EDGE_W'(EDGES - 1);

  spiState_t         state;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  halfLen;
  logic [EDGE_W-1:0] edgeIdx;
  logic [1:0]        rateQ;
  logic              lastTick;

  assign halfLen  = CNT_W'(HALF_MAX >> rateQ);
  assign lastTick = (cnt == halfLen - CNT_W'(1));
  assign busy     = (state != ST_IDLE);

  always_comb begin
    stb.load    = (state == ST_IDLE) && dataWr;
    stb.capture = (state == ST_RUN) && lastTick && !edgeIdx[0];
    stb.shift   = (state == ST_RUN) && lastTick && edgeIdx[0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      edgeIdx <= '0;
      rateQ   <= 2'b00;
      sclk    <= 1'b0;
      csN     <= 1'b1;
    end else begin
      case (state)
        ST_IDLE: begin
          if (dataWr) begin
            state   <= ST_RUN;
            cnt     <= '0;
            edgeIdx <= '0;
            rateQ   <= rateSel;
            csN     <= 1'b0;
          end
        end
        ST_RUN: begin
          if (lastTick) begin
            cnt  <= '0;
            sclk <= ~sclk;
            if (edgeIdx == LAST_EDGE) state <= ST_TAIL;
            else edgeIdx <= edgeIdx + EDGE_W'(1);
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        ST_TAIL: begin
          if (lastTick) begin
            state <= ST_IDLE;
            csN   <= 1'b1;
            cnt   <= '0;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R5: mode 0 keeps the clock low whenever the slave is deselected
  p_sclk_idle_low_r5: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !sclk);

  // R8: a busy period can only begin from a data write
  p_busy_from_write_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(dataWr));

  // R6: rate captured at start does not move during a transfer
  p_rate_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(rateQ));

endmodule

// File: rtl/spi_irq_dpath.sv
module spi_irq_dpath
  import spi_irq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int IRQ_N  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  spiStrobe_t        stb,
  input  logic              busy,
  input  logic              csrWr,
  input  logic [7:0]        wrData,
  input  logic              miso,
  input  logic              devIntN,
  output logic [7:0]        csrRd,
  output logic [DATA_W-1:0] dataRd,
  output logic              mosi,
  output logic [1:0]        rateSel,
  output logic [IRQ_N-1:0]  irqLine
);

  localparam int SEL_W = $clog2(IRQ_N);

  logic [5:0]        ctlQ;   // bits 7:2 of the control byte
  logic              syncA, syncB;
  logic              devIntActive;
  logic [DATA_W-1:0] txSh, rxSh;
  logic              lsbQ;
  logic [SEL_W-1:0]  irqSel;
  logic              irqEn, orderBit;

  assign irqSel       = ctlQ[5:4];
  assign rateSel      = ctlQ[3:2];
  assign irqEn        = ctlQ[1];
  assign orderBit     = ctlQ[0];
  assign devIntActive = ~syncB;

  assign csrRd  = {ctlQ, devIntActive, busy};
  assign dataRd = rxSh;
  assign mosi   = lsbQ ? txSh[0] : txSh[DATA_W-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctlQ  <= '0;
      syncA <= 1'b1;
      syncB <= 1'b1;
    end else begin
      if (csrWr) ctlQ <= wrData[7:2];
      syncA <= devIntN;
      syncB <= syncA;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txSh <= '0;
      rxSh <= '0;
      lsbQ <= 1'b0;
    end else begin
      if (stb.load) begin
        txSh <= wrData;
        lsbQ <= orderBit;
      end else if (stb.shift) begin
        txSh <= lsbQ ? (txSh >> 1) : (txSh << 1);
      end
      if (stb.capture)
        rxSh <= lsbQ ? {miso, rxSh[DATA_W-1:1]} : {rxSh[DATA_W-2:0], miso};
    end
  end

  for (genvar i = 0; i < IRQ_N; i++) begin : g_route
    assign irqLine[i] = irqEn && devIntActive && (irqSel == SEL_W'(i));
  end

  // R2: never more than one routed line at a time
  p_irq_onehot_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(irqLine));

  // R4: status only sets after the input has been low two edges back
  p_sync_delay_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(devIntActive) |-> $past(!devIntN, 2));

  // R7: captured bit order holds for the whole transfer
  p_order_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(lsbQ));

  // R9: while busy the tx byte moves only on shift strobes
  p_tx_no_reload_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !stb.shift) |=> $stable(txSh));

endmodule

// File: rtl/spi_irq_master.sv
module spi_irq_master
  import spi_irq_pkg::*;
#(
  parameter int HALF_MAX = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csrWr,
  input  logic       dataWr,
  input  logic [7:0] wrData,
  output logic [7:0] csrRd,
  output logic [7:0] dataRd,
  output logic       sclk,
  output logic       mosi,
  input  logic       miso,
  output logic       csN,
  input  logic       devIntN,
  output logic [3:0] irqLine
);

  localparam int DATA_W = 8;
  localparam int IRQ_N  = 4;

  spiStrobe_t stb;
  logic       busy;
  logic [1:0] rateSel;

  spi_irq_ctrl #(.HALF_MAX(HALF_MAX), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .dataWr(dataWr), .rateSel(rateSel),
    .stb(stb), .sclk(sclk), .csN(csN), .busy(busy)
  );

  spi_irq_dpath #(.DATA_W(DATA_W), .IRQ_N(IRQ_N)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .busy(busy), .csrWr(csrWr),
    .wrData(wrData), .miso(miso), .devIntN(devIntN), .csrRd(csrRd),
    .dataRd(dataRd), .mosi(mosi), .rateSel(rateSel), .irqLine(irqLine)
  );

endmodule

// File: tb/tb_spi_irq_master.sv
module tb_spi_irq_master;

  localparam int HALF_MAX = 8;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       csrWr = 1'b0, dataWr = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] csrRd, dataRd;
  logic       sclk, mosi, csN;
  logic       miso = 1'b0;
  logic       devIntN = 1'b1;
  logic [3:0] irqLine;

  spi_irq_master #(.HALF_MAX(HALF_MAX)) dut (
    .clk(clk), .rstN(rstN), .csrWr(csrWr), .dataWr(dataWr), .wrData(wrData),
    .csrRd(csrRd), .dataRd(dataRd), .sclk(sclk), .mosi(mosi), .miso(miso),
    .csN(csN), .devIntN(devIntN), .irqLine(irqLine)
  );

  // 200 MHz: 5 time units per period
  always begin
    #2 clk = 1'b1;
    #3 clk = 1'b0;
  end

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference state
  bit       active = 0;
  int       e = 0, h = HALF_MAX;
  bit       lsb = 0;
  bit [7:0] tx = 0, slaveCur = 0, expRx = 0, slaveByte = 8'hA5;
  bit [5:0] ctl = 0;
  bit       q1 = 1, q2 = 1;

  always @(posedge clk) begin
    if (!rstN) begin
      active = 0; e = 0; h = HALF_MAX; ctl = 0; q1 = 1; q2 = 1; expRx = 0; lsb = 0;
    end else begin
      bit wasActive;
      wasActive = active;
      if (active) begin
        e++;
        if (e >= 17 * h) begin
          active = 0;
          expRx = slaveCur;
        end
      end
      // R9: start only from idle
      if (!wasActive && dataWr) begin
        active = 1; e = 0;
        h = HALF_MAX >> ctl[3:2];
        lsb = ctl[0];
        tx = wrData;
        slaveCur = slaveByte;
      end
      if (csrWr) ctl = wrData[7:2];
      q2 = q1;
      q1 = devIntN;
    end
  end

  always @(negedge clk) begin
    if (rstN && !done) begin
      int t, k, ei;
      t = active ? e / h : 16;
      k = t / 2;
      ei = (ctl[1] && !q2) ? (1 << ctl[5:4]) : 0;
      chk("R1 R4 R8 csr", csrRd, {ctl, ~q2, active});
      chk("R5 R6 csN", csN, active ? 0 : 1);
      chk("R5 R6 sclk", sclk, (active && t < 16) ? t % 2 : 0);
      if (active && t < 16)
        chk("R7 R9 mosi", mosi, lsb ? tx[k] : tx[7 - k]);
      if (!active) chk("R10 rx", dataRd, expRx);
      chk("R2 R3 irq", irqLine, ei);
      miso = (active && t < 16) ? (lsb ? slaveCur[k] : slaveCur[7 - k]) : 1'b0;
    end
  end

  task automatic wrCsr(input logic [7:0] v);
    @(negedge clk); csrWr = 1'b1; wrData = v;
    @(negedge clk); csrWr = 1'b0;
  endtask

  task automatic sendByte(input logic [7:0] v);
    @(negedge clk); dataWr = 1'b1; wrData = v;
    @(negedge clk); dataWr = 1'b0;
  endtask

  task automatic waitIdle();
    @(negedge clk);
    while (active) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // reset state (R1)
    chk("R1 reset csr", csrRd, 0);
    chk("R5 reset csN", csN, 1);
    chk("R5 reset sclk", sclk, 0);
    chk("R3 reset irq", irqLine, 0);
    chk("R10 reset rx", dataRd, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R1: bits 1:0 not writable
    wrCsr(8'hFF);
    @(negedge clk);
    chk("R1 readonly bits", csrRd, 8'hFC);
    wrCsr(8'h00);

    // R5 R6 R7 R10: every rate with both orders, R9 extra writes mid-transfer
    for (int r = 0; r < 4; r++) begin
      for (int o = 0; o < 2; o++) begin
        slaveByte = 8'h3C ^ 8'(r * 37 + o * 91);
        wrCsr({2'b00, 2'(r), 1'b0, 1'(o), 2'b11});
        sendByte(8'hC5 ^ 8'(r * 19 + o * 7));
        repeat (3) @(negedge clk);
        sendByte(8'h5A);                               // R9: ignored
        wrCsr({2'b00, ~2'(r), 1'b0, ~1'(o), 2'b00});   // R7: latched
        waitIdle();
      end
    end

    // R2 R4: route to each line
    for (int s = 0; s < 4; s++) begin
      wrCsr({2'(s), 2'b11, 1'b1, 1'b0, 2'b00});
      @(negedge clk); devIntN = 1'b0;
      repeat (5) @(negedge clk);
      devIntN = 1'b1;
      repeat (5) @(negedge clk);
    end

    // R3: enable off, interrupt active
    wrCsr(8'b1011_0000);
    @(negedge clk); devIntN = 1'b0;
    repeat (6) @(negedge clk);
    // interrupt toggling during a transfer, then enable on
    slaveByte = 8'h81;
    sendByte(8'h7E);
    repeat (10) @(negedge clk);
    wrCsr(8'b0111_1000);
    repeat (6) @(negedge clk);
    devIntN = 1'b1;
    waitIdle();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule